// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit core's load/store stage and a word-wide synchronous data memory. For every request it forms the effective byte address as a base value plus a sign-extended 12-bit offset. It turns that address into a word index and, for stores, into per-lane write enables and lane-replicated write data. The memory is little-endian, so the lowest byte address selects the least significant lane of a word.

On loads the memory answers one cycle after the request. The block keeps the access size, the signedness and the low address bits in registers for that cycle. It can then pick the right lanes out of the returned word and sign- or zero-extend them to 32 bits. A halfword or word access at an address that does not fit its natural alignment is not issued to memory. Instead it raises a misaligned-load or misaligned-store flag with the matching trap cause code.

Top module: `lsu_align`

## Requirements
- R1: The word address driven to memory equals (base + sign-extended 12-bit offset) shifted right by 2. The offset may be negative.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word, and 3 behaves as word. An aligned store drives byte-enables as follows: a byte store enables the single lane given by address bits 1:0 (bit n enables bits 8n+7:8n of the word). A halfword store enables 0011 when address bit 1 is 0 and 1100 when it is 1. A word store enables 1111.
- R3: Store write data repeats the low byte in all four lanes for a byte store and the low halfword in both halves for a halfword store. A word store passes the data unchanged.
- R4: A signed byte or halfword load returns the selected value sign-extended to 32 bits.
- R5: An unsigned byte or halfword load returns the selected value zero-extended to 32 bits.
- R6: Lane selection is little-endian. A byte load at address bits 1:0 = n returns bits 8n+7:8n of the memory word. A halfword load returns bits 15:0 or 31:16 depending on address bit 1. A word load returns the whole word.
- R7: A valid load is misaligned when it is a halfword load with address bit 0 set, or a word load with address bits 1:0 non-zero. Such a load raises the misaligned-load flag and drives cause 4. It issues no memory request and produces no read return. Without a valid request no flag is raised and the cause is 0.
- R8: A valid store that is misaligned under the same rule raises the misaligned-store flag and drives cause 6. It issues no memory request and all byte-enables are 0.
- R9: Read data is valid exactly one cycle after an aligned load request. It is extended using the size, signedness and low address bits captured with that request, even when a different request is presented in the return cycle. Stores produce no read return.
- R10: While reset is asserted, and in the cycle after it, no read return is signalled, including for a load presented during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend sub-word load |
| req_base | input | 32 | Base address value |
| req_offset | input | 12 | Signed address offset |
| req_wdata | input | 32 | Store data, right-justified |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 30 | Word index |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Word returned one cycle after mem_req |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 32 | Extended load result |
| misalign_ld | output | 1 | Misaligned load flag |
| misalign_st | output | 1 | Misaligned store flag |
| fault_cause | output | 4 | Trap cause: 0, 4 or 6 |

## Verification
The assertions assume that the memory returns read data exactly one cycle after an aligned load strobe and holds it during that cycle. They also assume that the request inputs are stable between clock edges. The bench drives every request at the falling edge and presents a fixed known word on the read port in the return cycle. Result lanes can therefore be predicted from the address alone. Reset is asserted at time zero and is released only at a falling edge, so the first edge that the properties sample already sees a defined reset.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam logic [3:0] CAUSE_NONE     = 4'd0;
  localparam logic [3:0] CAUSE_LD_MISAL = 4'd4;
  localparam logic [3:0] CAUSE_ST_MISAL = 4'd6;
endpackage

// File: rtl/lsu_ea_check.sv
module lsu_ea_check
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              misal
);
  localparam int EXT_W = ADDR_W - OFF_W;

  always_comb begin
    ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    unique case (size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = ea[0];
      default: misal = |ea[LANE_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0] wd
);
  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_byte;
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          lane_en   = (lo == LANE_W'(i));
          lane_byte = wdata[7:0];
        end
        SZ_HALF: begin
          lane_en   = (lo[LANE_W-1:1] == (LANE_W-1)'(i / 2));
          lane_byte = wdata[8*(i%2) +: 8];
        end
        default: begin
          lane_en   = 1'b1;
          lane_byte = wdata[8*i +: 8];
        end
      endcase
    end
    assign be[i]         = lane_en;
    assign wd[8*i +: 8]  = lane_byte;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  acc_size_e         size,
  input  logic              uns,
  input  logic [LANE_W-1:0] lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] data
);
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  always_comb begin
    byte_v = rdata[{lo, 3'b000} +: 8];
    half_v = rdata[{lo[LANE_W-1:1], 4'b0000} +: 16];
    unique case (size)
      SZ_BYTE: data = uns ? {{(DATA_W-8){1'b0}}, byte_v}
                          : {{(DATA_W-8){byte_v[7]}}, byte_v};
      SZ_HALF: data = uns ? {{(DATA_W-16){1'b0}}, half_v}
                          : {{(DATA_W-16){half_v[15]}}, half_v};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [1:0]                  req_size,
  input  logic                        req_unsigned,
  input  logic [ADDR_W-1:0]           req_base,
  input  logic [OFF_W-1:0]            req_offset,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W/8-1:0]         mem_be,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        misalign_ld,
  output logic                        misalign_st,
  output logic [3:0]                  fault_cause
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  acc_size_e           sz;
  logic [ADDR_W-1:0]   ea;
  logic                misal;
  logic [LANES-1:0]    st_be;
  logic [DATA_W-1:0]   st_wd;
  logic                load_go;

  acc_size_e           ctx_size;
  logic                ctx_uns;
  logic [LANE_W-1:0]   ctx_lo;

  assign sz = acc_size_e'(req_size);

  lsu_ea_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_ea (
    .base(req_base), .offset(req_offset), .size(sz), .ea(ea), .misal(misal)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_steer (
    .size(sz), .lo(ea[LANE_W-1:0]), .wdata(req_wdata), .be(st_be), .wd(st_wd)
  );

  always_comb begin
    mem_req     = req_valid & ~misal;
    mem_we      = mem_req & req_write;
    mem_be      = mem_we ? st_be : '0;
    mem_addr    = ea[ADDR_W-1:LANE_W];
    mem_wdata   = st_wd;
    misalign_ld = req_valid & misal & ~req_write;
    misalign_st = req_valid & misal & req_write;
    if (misalign_ld)      fault_cause = CAUSE_LD_MISAL;
    else if (misalign_st) fault_cause = CAUSE_ST_MISAL;
    else                  fault_cause = CAUSE_NONE;
    load_go     = req_valid & ~req_write & ~misal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      ctx_size <= SZ_BYTE;
      ctx_uns  <= 1'b0;
      ctx_lo   <= '0;
    end else begin
      rd_valid <= load_go;
      if (load_go) begin
        ctx_size <= sz;
        ctx_uns  <= req_unsigned;
        ctx_lo   <= ea[LANE_W-1:0];
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ext (
    .size(ctx_size), .uns(ctx_uns), .lo(ctx_lo), .rdata(mem_rdata), .data(rd_data)
  );

  // R2
  be_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && sz == SZ_BYTE) |-> $countones(mem_be) == 1);

  // R7
  ld_misal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    misalign_ld |-> (!mem_req && fault_cause == CAUSE_LD_MISAL));

  // R7
  ld_misal_no_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (misalign_ld && !mem_req) |=> !rd_valid);

  // R8
  st_misal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    misalign_st |-> (!mem_req && mem_be == '0 && fault_cause == CAUSE_ST_MISAL));

  // R9
  rd_return_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> rd_valid);

  // R9
  st_no_return_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || !req_valid) |=> !rd_valid);

  // R5
  zext_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ctx_uns && ctx_size == SZ_BYTE) |-> rd_data[DATA_W-1:8] == '0);

  // R10
  rst_idle_chk: assert property (@(posedge clk) rst |=> !rd_valid);
endmodule

// File: tb/lsu_align_tb.sv
module lsu_align_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MWORD = 32'h8765F0A1;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic        uns;
    logic [31:0] base;
    logic [11:0] off;
    logic [31:0] wd;
    logic [29:0] eaddr;
    logic [3:0]  ebe;
    logic [31:0] ewd;
    logic [31:0] erd;
    logic [3:0]  ecause;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 32'h100,  12'h000, 32'h0,        30'h40,  4'h0, 32'h0,        32'hFFFFFFA1, 4'd0},
    '{1'b0, 2'd0, 1'b1, 32'h101,  12'h000, 32'h0,        30'h40,  4'h0, 32'h0,        32'h000000F0, 4'd0},
    '{1'b0, 2'd0, 1'b0, 32'h102,  12'h000, 32'h0,        30'h40,  4'h0, 32'h0,        32'h00000065, 4'd0},
    '{1'b0, 2'd0, 1'b1, 32'h100,  12'h003, 32'h0,        30'h40,  4'h0, 32'h0,        32'h00000087, 4'd0},
    '{1'b0, 2'd1, 1'b0, 32'h102,  12'h000, 32'h0,        30'h40,  4'h0, 32'h0,        32'hFFFF8765, 4'd0},
    '{1'b0, 2'd1, 1'b1, 32'h100,  12'h000, 32'h0,        30'h40,  4'h0, 32'h0,        32'h0000F0A1, 4'd0},
    '{1'b0, 2'd2, 1'b0, 32'h010,  12'hFFC, 32'h0,        30'h03,  4'h0, 32'h0,        32'h8765F0A1, 4'd0},
    '{1'b0, 2'd1, 1'b0, 32'h101,  12'h000, 32'h0,        30'h0,   4'h0, 32'h0,        32'h0,        4'd4},
    '{1'b0, 2'd2, 1'b0, 32'h102,  12'h000, 32'h0,        30'h0,   4'h0, 32'h0,        32'h0,        4'd4},
    '{1'b1, 2'd0, 1'b0, 32'h203,  12'h000, 32'h123456AB, 30'h80,  4'h8, 32'hABABABAB, 32'h0,        4'd0},
    '{1'b1, 2'd1, 1'b0, 32'h202,  12'h000, 32'hCAFEBEEF, 30'h80,  4'hC, 32'hBEEFBEEF, 32'h0,        4'd0},
    '{1'b1, 2'd1, 1'b0, 32'h200,  12'h000, 32'hCAFEBEEF, 30'h80,  4'h3, 32'hBEEFBEEF, 32'h0,        4'd0},
    '{1'b1, 2'd2, 1'b0, 32'h1000, 12'h800, 32'h13579BDF, 30'h200, 4'hF, 32'h13579BDF, 32'h0,        4'd0},
    '{1'b1, 2'd2, 1'b0, 32'h201,  12'h000, 32'h13579BDF, 30'h0,   4'h0, 32'h0,        32'h0,        4'd6},
    '{1'b1, 2'd1, 1'b0, 32'h203,  12'h000, 32'hCAFEBEEF, 30'h0,   4'h0, 32'h0,        32'h0,        4'd6},
    '{1'b1, 2'd0, 1'b0, 32'h201,  12'h000, 32'h000000C3, 30'h80,  4'h2, 32'hC3C3C3C3, 32'h0,        4'd0},
    '{1'b0, 2'd1, 1'b0, 32'h004,  12'hFFE, 32'h0,        30'h0,   4'h0, 32'h0,        32'hFFFF8765, 4'd0},
    '{1'b0, 2'd1, 1'b1, 32'h7FF,  12'h7FF, 32'h0,        30'h3FF, 4'h0, 32'h0,        32'h00008765, 4'd0},
    '{1'b0, 2'd3, 1'b0, 32'h100,  12'h000, 32'h0,        30'h40,  4'h0, 32'h0,        32'h8765F0A1, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_unsigned = 1'b0;
  logic [31:0] req_base = '0;
  logic [11:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_rdata = MWORD;
  logic        mem_req, mem_we, rd_valid, misalign_ld, misalign_st;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be, fault_cause;
  logic [31:0] mem_wdata, rd_data;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .misalign_ld(misalign_ld), .misalign_st(misalign_st), .fault_cause(fault_cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [1:0] s, input logic u,
                       input logic [31:0] b, input logic [11:0] o, input logic [31:0] d);
    req_valid = v; req_write = w; req_size = s; req_unsigned = u;
    req_base = b; req_offset = o; req_wdata = d;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    // R10: reset state, and a load presented during reset yields no return
    repeat (2) @(negedge clk);
    drive(1'b1, 1'b0, 2'd2, 1'b0, 32'h100, 12'h0, 32'h0);
    @(negedge clk);
    chk("R10 rd_valid in reset", {31'b0, rd_valid}, 32'd0);
    drive(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 12'h0, 32'h0);
    rst = 1'b0;
    #1;
    chk("R10 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
    chk("R10 mem_req idle", {31'b0, mem_req}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      logic ok;
      v = VECS[k];
      ok = (v.ecause == 4'd0);
      @(negedge clk);
      drive(1'b1, v.wr, v.sz, v.uns, v.base, v.off, v.wd);
      #1;
      chk(v.wr ? "R8 cause" : "R7 cause", {28'b0, fault_cause}, {28'b0, v.ecause});
      chk(v.wr ? "R8 mem_req" : "R7 mem_req", {31'b0, mem_req}, {31'b0, ok});
      if (ok) chk("R1 word address", {2'b0, mem_addr}, {2'b0, v.eaddr});
      if (v.wr) chk(ok ? "R2 byte enables" : "R8 byte enables", {28'b0, mem_be}, {28'b0, v.ebe});
      if (v.wr && ok) chk("R3 write data", mem_wdata, v.ewd);
      @(negedge clk);
      drive(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 12'h0, 32'h0);
      #1;
      chk("R9 rd_valid", {31'b0, rd_valid}, {31'b0, ok && !v.wr});
      if (ok && !v.wr) begin
        if (v.sz >= 2'd2) chk("R6 word load", rd_data, v.erd);
        else if (v.uns)   chk("R5 zero extend", rd_data, v.erd);
        else              chk("R4 sign extend", rd_data, v.erd);
      end
    end

    // R7: no valid request, misaligned address raises nothing
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd2, 1'b0, 32'h3, 12'h0, 32'h0);
    #1;
    chk("R7 idle flag", {30'b0, misalign_ld, misalign_st}, 32'd0);
    chk("R7 idle cause", {28'b0, fault_cause}, 32'd0);

    // R9: back-to-back load then store; return uses captured load context
    @(negedge clk);
    drive(1'b1, 1'b0, 2'd0, 1'b1, 32'h101, 12'h0, 32'h0);
    @(negedge clk);
    drive(1'b1, 1'b1, 2'd2, 1'b0, 32'h200, 12'h0, 32'h11223344);
    #1;
    chk("R9 rd_valid back-to-back", {31'b0, rd_valid}, 32'd1);
    chk("R9 data uses captured context", rd_data, 32'h000000F0);
    chk("R9 store issued meanwhile", {31'b0, mem_we}, 32'd1);
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 12'h0, 32'h0);
    #1;
    chk("R9 no return after store", {31'b0, rd_valid}, 32'd0);

    // R6: byte at lane 2 with a different memory word
    @(negedge clk);
    drive(1'b1, 1'b0, 2'd0, 1'b0, 32'h20, 12'h2, 32'h0);
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 12'h0, 32'h0);
    mem_rdata = 32'h00C40000;
    #1;
    chk("R6 lane 2 byte", rd_data, 32'hFFFFFFC4);
    mem_rdata = MWORD;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule